// File: doc/BRIEF.md
# Reload-Latching Watchdog Timer

This block is a countdown watchdog. Software talks to it through a single write port. After any external reset it sits idle. The first write of a nonzero value arms it, and that value is kept as the timeout, counted in clock cycles. From then on every write restarts the countdown from the kept value. The data carried by those later writes is thrown away.

When software stops writing and the count runs out, the block raises a one-cycle reset request for the rest of the system. In the same cycle it sets a sticky status flag and drops back to the idle state, forgetting the kept timeout. The flag survives this self-generated reset, so code running afterwards can tell a timeout from an external reset. Writing zero while idle clears the flag and leaves the timer disarmed. An external reset clears everything.

Top module: `wdt_reload_latch`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, wd_rst_o, timeout_flag_o and armed_o are all 0.
- R2: While disarmed, a write (wr_en_i=1) with nonzero wr_data_i=N sets armed_o=1 after that edge. With no further writes, wd_rst_o is high exactly N cycles after the write edge.
- R3: While armed, a write restarts the countdown from the first latched N, whatever wr_data_i holds. This includes zero, which neither disarms the timer nor changes timeout_flag_o.
- R4: Writes spaced more closely than N cycles keep wd_rst_o at 0 and armed_o at 1 indefinitely.
- R5: On expiry, wd_rst_o is high for exactly one cycle, and armed_o goes to 0 in that same cycle.
- R6: timeout_flag_o goes to 1 in the expiry cycle and stays at 1 while disarmed. A later nonzero arming write does not clear it.
- R7: A write of zero while disarmed clears timeout_flag_o and leaves armed_o at 0.
- R8: Expiry discards the latched timeout, so the next arming write sets a new N that is used from then on.
- R9: Asserting rst_ni low clears timeout_flag_o, armed_o and the latched timeout. Afterwards a fresh arming write is needed.
- R10: A write in the cycle in which the count would reach zero reloads the timer instead of expiring. No wd_rst_o pulse appears and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the count advances once per rising edge |
| rst_ni | input | 1 | External asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe to the timeout register |
| wr_data_i | input | 16 | Write data; used only by the arming write or a zero clear |
| wd_rst_o | output | 1 | One-cycle reset request on expiry |
| timeout_flag_o | output | 1 | Sticky flag showing that the last reset came from expiry |
| armed_o | output | 1 | Timer is armed and counting |

## Verification
The timer is armed with different timeouts, and the reset pulse is expected in exactly the Nth cycle. This separates a correct count from one that is off by one cycle. Reload writes carry data that differs from the latched value, including zero, so the run can tell a correctly latched timeout from one rewritten by later data. A write placed in the final cycle of the count shows that a reload takes priority over expiry. Zero and nonzero writes are made both while idle and while armed, which shows that only an idle zero write clears the flag. An external reset is applied with the flag set to show that the flag is cleared and re-arming is required.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  typedef struct packed {
    logic arm_load;  // first write: latch value and start
    logic kick;      // reload from latched value
    logic clr_flag;  // idle zero write: clear status
  } wr_cmd_t;
endpackage

// File: rtl/wdt_wr_decode.sv
`timescale 1ns/1ps
module wdt_wr_decode
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             armed_i,
  output wr_cmd_t          cmd_o
);
  logic data_zero;
  assign data_zero = (wr_data_i == '0);

  always_comb begin
    cmd_o          = '0;
    cmd_o.arm_load = wr_en_i && !armed_i && !data_zero;
    cmd_o.kick     = wr_en_i && armed_i;
    cmd_o.clr_flag = wr_en_i && !armed_i && data_zero;
  end
endmodule

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  wr_cmd_t          cmd_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             armed_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] latch_q, cnt_q;
  logic             armed_q;

  // count reaches zero on this edge unless a reload arrives
  assign expire_o = armed_q && !cmd_i.kick && (cnt_q == ONE);
  assign armed_o  = armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (cmd_i.arm_load) begin
      latch_q <= load_val_i;
      cnt_q   <= load_val_i;
      armed_q <= 1'b1;
    end else if (cmd_i.kick) begin
      cnt_q   <= latch_q;
    end else if (expire_o) begin
      latch_q <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (armed_q) begin
      cnt_q   <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/wdt_status.sv
`timescale 1ns/1ps
module wdt_status
  import wdt_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    expire_i,
  input  wr_cmd_t cmd_i,
  output logic    wd_rst_o,
  output logic    flag_o
);
  logic pulse_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      pulse_q <= expire_i;
      if (expire_i)           flag_q <= 1'b1;
      else if (cmd_i.clr_flag) flag_q <= 1'b0;
    end
  end

  assign wd_rst_o = pulse_q;
  assign flag_o   = flag_q;
endmodule

// File: rtl/wdt_reload_latch.sv
`timescale 1ns/1ps
module wdt_reload_latch
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             wd_rst_o,
  output logic             timeout_flag_o,
  output logic             armed_o
);
  wr_cmd_t cmd;
  logic    armed, expire;

  wdt_wr_decode #(.CNT_W(CNT_W)) u_dec (
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .armed_i   (armed),
    .cmd_o     (cmd)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .load_val_i (wr_data_i),
    .armed_o    (armed),
    .expire_o   (expire)
  );

  wdt_status u_sts (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .expire_i (expire),
    .cmd_i    (cmd),
    .wd_rst_o (wd_rst_o),
    .flag_o   (timeout_flag_o)
  );

  assign armed_o = armed;
endmodule

// File: rtl/wdt_reload_latch_chk.sv
`timescale 1ns/1ps
module wdt_reload_latch_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic             wd_rst_o,
  input logic             timeout_flag_o,
  input logic             armed_o
);
  // R5
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_rst_o |=> !wd_rst_o);

  // R5
  pulse_disarms_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_rst_o |-> !armed_o && $past(armed_o) && !$past(wr_en_i));

  // R6
  pulse_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_rst_o |-> timeout_flag_o);

  // R2
  arm_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_o) |-> $past(wr_en_i) && ($past(wr_data_i) != '0));

  // R7
  flag_clear_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(timeout_flag_o) |-> $past(wr_en_i) && ($past(wr_data_i) == '0) && !$past(armed_o));

  // R3
  reload_keeps_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && armed_o) |=> armed_o && !wd_rst_o && $stable(timeout_flag_o));
endmodule

bind wdt_reload_latch wdt_reload_latch_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_en_i        (wr_en_i),
  .wr_data_i      (wr_data_i),
  .wd_rst_o       (wd_rst_o),
  .timeout_flag_o (timeout_flag_o),
  .armed_o        (armed_o)
);

// File: tb/wdt_reload_latch_tb_top.sv
`timescale 1ns/1ps
module wdt_reload_latch_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        wd_rst_o, timeout_flag_o, armed_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  wdt_reload_latch dut_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_en_i        (wr_en_i),
    .wr_data_i      (wr_data_i),
    .wd_rst_o       (wd_rst_o),
    .timeout_flag_o (timeout_flag_o),
    .armed_o        (armed_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic outs(input string req, input int rst_e, input int flag_e, input int arm_e);
    chk(req, "wd_rst_o", int'(wd_rst_o), rst_e);
    chk(req, "timeout_flag_o", int'(timeout_flag_o), flag_e);
    chk(req, "armed_o", int'(armed_o), arm_e);
  endtask

  task automatic wait_n(input int k);
    for (int i = 0; i < k; i++) @(negedge clk_i);
  endtask

  // called at a negedge; the write is captured at the next posedge, returns at following negedge
  task automatic wr(input logic [15:0] d);
    wr_en_i   = 1'b1;
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i   = 1'b0;
    wr_data_i = 16'hA5A5;
  endtask

  task automatic ext_reset();
    rst_ni = 1'b0;
    wait_n(2);
    outs("R1", 0, 0, 0);
    rst_ni = 1'b1;
    wait_n(1);
    outs("R1", 0, 0, 0);
  endtask

  task automatic expire_after(input string req, input int n, input int flag_before);
    wait_n(n - 1);
    outs(req, 0, flag_before, 1);
    wait_n(1);
    outs(req, 1, 1, 0);
    wait_n(1);
    outs("R5", 0, 1, 0);
  endtask

  task automatic t_reset();
    ext_reset();
    wait_n(5);
    outs("R1", 0, 0, 0);
  endtask

  task automatic t_arm_expire();
    wr(16'd5);
    outs("R2", 0, 0, 1);
    expire_after("R2", 5, 0);
    wr(16'd1);
    outs("R2", 0, 1, 1);
    wait_n(1);
    outs("R5", 1, 1, 0);
    wait_n(1);
    outs("R5", 0, 1, 0);
  endtask

  task automatic t_reload_ignores_data();
    ext_reset();
    wr(16'd8);
    wait_n(5);
    wr(16'd3);
    wait_n(3);
    outs("R3", 0, 0, 1);  // data 3 would have expired here
    wait_n(4);
    wr(16'd0);             // zero while armed: still a reload
    outs("R3", 0, 0, 1);
    expire_after("R3", 8, 0);
  endtask

  task automatic t_periodic_kick();
    int pulses = 0;
    ext_reset();
    wr(16'd6);
    for (int i = 0; i < 20; i++) begin
      wait_n(4);
      if (wd_rst_o || !armed_o) pulses++;
      wr(16'hFFFF);
      if (wd_rst_o || !armed_o) pulses++;
    end
    chk("R4", "missed kicks", pulses, 0);
    outs("R4", 0, 0, 1);
    expire_after("R4", 6, 0);
  endtask

  task automatic t_last_cycle_kick();
    ext_reset();
    wr(16'd4);
    wait_n(3);
    wr(16'd9);             // captured on the edge that would reach zero
    outs("R10", 0, 0, 1);
    expire_after("R10", 4, 0);
  endtask

  task automatic t_flag_sticky_and_clear();
    // flag is set from previous test; nonzero re-arm keeps it
    wait_n(7);
    outs("R6", 0, 1, 0);
    wr(16'd3);
    outs("R6", 0, 1, 1);
    expire_after("R8", 3, 1);   // new value 3, not the old 4
    wr(16'd0);
    outs("R7", 0, 0, 0);
    wait_n(4);
    outs("R7", 0, 0, 0);
    wr(16'd0);
    outs("R7", 0, 0, 0);
  endtask

  task automatic t_ext_reset_clears();
    wr(16'd2);
    expire_after("R6", 2, 0);
    wr(16'd10);
    outs("R9", 0, 1, 1);
    ext_reset();
    wait_n(15);
    outs("R9", 0, 0, 0);
    wr(16'd7);
    expire_after("R9", 7, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    outs("R1", 0, 0, 0);
    wait_n(1);
    rst_ni = 1'b1;
    wait_n(1);
    outs("R1", 0, 0, 0);
    t_reset();
    t_arm_expire();
    t_reload_ignores_data();
    t_periodic_kick();
    t_last_cycle_kick();
    t_flag_sticky_and_clear();
    t_ext_reset_clears();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule